// File: doc/BRIEF.md
# Digital Potentiometer Register Executor

This block holds the state of a 1024-position digital potentiometer: one 10-bit wiper register and four 10-bit data registers. A serial front end supplies a command byte, the read/write bit taken from the address byte, and a data word split into a high and a low byte. The block decodes these, runs the operation on its registers, and returns read data as two bytes. It decodes the wiper register into a one-hot select for the tap switch array.

Writes that target a data register model nonvolatile storage. A pending store of this kind starts a busy period when the front end reports the stop condition. The period lasts a parameterised number of clock cycles. While it runs, the block accepts no command, so a host can poll until it ends.

Top module: `pot_exec`

## Requirements
- R1: After reset the wiper register and all four data registers are zero, `busy` is low, `rd_valid` is low and `tap_sel` has only bit 0 set.
- R2: A command byte is laid out as opcode in bits 7:5, register pointer in bits 3:2, and bits 4, 1 and 0 reserved as zero. A command with any reserved bit set is ignored and changes no register.
- R3: Opcode 100 with `rw_bit`=1 reads the wiper. In the cycle after the command, `rd_valid` is high, `rd_hi` holds wiper bits 9:8 in its bits 1:0 with zeros above, and `rd_lo` holds wiper bits 7:0.
- R4: Opcode 101 with `rw_bit`=0 loads the wiper from {`wr_hi`[1:0], `wr_lo`}. Bits 7:2 of `wr_hi` are ignored.
- R5: Opcode 101 with `rw_bit`=1 reads the data register chosen by the pointer (00, 01, 10, 11 pick registers 0 to 3), in the same byte format as R3.
- R6: Opcode 110 with `rw_bit`=0 loads the pointed data register from {`wr_hi`[1:0], `wr_lo`}.
- R7: Opcode 110 with `rw_bit`=1 copies the pointed data register into the wiper.
- R8: Opcode 111 with `rw_bit`=0 copies the wiper into the pointed data register.
- R9: `tap_sel` always has exactly one bit set, at the index equal to the wiper value. Value 0x000 selects bit 0 and value 0x3FF selects bit 1023. It follows a wiper change one cycle after the command.
- R10: A stop after an R6 or R8 command raises `busy` on the next clock. `busy` then stays high for exactly `BUSY_CYCLES` cycles. A stop with no such store pending leaves `busy` low.
- R11: While `busy` is high, every command is ignored: no read data and no register change.
- R12: Opcode and read/write combinations not listed in R3 to R8 are ignored and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe: a command with its data is present |
| cmd_byte | input | 8 | Command byte |
| rw_bit | input | 1 | Read/write bit of the address byte, 1 = read |
| wr_hi | input | 8 | High data byte, bits 1:0 used |
| wr_lo | input | 8 | Low data byte |
| stop | input | 1 | One-cycle strobe: stop condition seen on the bus |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_hi | output | 8 | Read data high byte |
| rd_lo | output | 8 | Read data low byte |
| tap_sel | output | 1024 | One-hot tap switch enable |
| busy | output | 1 | Nonvolatile store in progress |

## Verification
Every register update and every read result is registered once. A command driven before one rising edge therefore shows its result right after that edge. The bench drives and samples on falling edges, so it checks `rd_valid`, the read bytes and `tap_sel` at the first falling edge after the command. `busy` rises at the edge that samples `stop`. The bench counts falling-edge samples with `busy` high and expects exactly `BUSY_CYCLES`. Commands that must be ignored are followed by a read through the normal command path to show that the register kept its value.

// File: rtl/pot_exec.sv
module pot_exec #(
  parameter int W = 10,
  parameter int BUSY_CYCLES = 250000,
  localparam int TAPS = 1 << W,
  localparam int CW = $clog2(BUSY_CYCLES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_byte,
  input  logic            rw_bit,
  input  logic [7:0]      wr_hi,
  input  logic [7:0]      wr_lo,
  input  logic            stop,
  output logic            rd_valid,
  output logic [7:0]      rd_hi,
  output logic [7:0]      rd_lo,
  output logic [TAPS-1:0] tap_sel,
  output logic            busy
);

  logic [W-1:0] wcr;
  logic [W-1:0] dr [4];
  logic         nv_pend;
  logic [CW-1:0] cnt;

  wire [2:0]   op     = cmd_byte[7:5];
  wire [1:0]   ptr    = cmd_byte[3:2];
  wire         fmt_ok = ~|{cmd_byte[4], cmd_byte[1:0]};
  wire         go     = cmd_valid && !busy && fmt_ok;
  wire [W-1:0] word   = {wr_hi[W-9:0], wr_lo};
  wire [W-1:0] rsel   = (op == 3'b100) ? wcr : dr[ptr];
  wire [15:0]  rwide  = 16'(rsel);

  logic unused_hi;
  assign unused_hi = ^wr_hi[7:W-8];

  assign tap_sel = {{(TAPS-1){1'b0}}, 1'b1} << wcr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcr      <= '0;
      for (int i = 0; i < 4; i++) dr[i] <= '0;
      nv_pend  <= 1'b0;
      busy     <= 1'b0;
      cnt      <= '0;
      rd_valid <= 1'b0;
      rd_hi    <= '0;
      rd_lo    <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end else if (stop && nv_pend) begin
        busy    <= 1'b1;
        cnt     <= CW'(BUSY_CYCLES - 1);
        nv_pend <= 1'b0;
      end
      if (go) begin
        case ({op, rw_bit})
          4'b1001, 4'b1011: begin
            rd_valid <= 1'b1;
            rd_hi    <= rwide[15:8];
            rd_lo    <= rwide[7:0];
          end
          4'b1010: wcr <= word;
          4'b1100: begin
            dr[ptr] <= word;
            nv_pend <= 1'b1;
          end
          4'b1101: wcr <= dr[ptr];
          4'b1110: begin
            dr[ptr] <= wcr;
            nv_pend <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/pot_exec_chk.sv
module pot_exec_chk #(
  parameter int TAPS = 1024
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [7:0]      cmd_byte,
  input logic            stop,
  input logic            rd_valid,
  input logic            busy,
  input logic [TAPS-1:0] tap_sel
);

  // R9
  tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_sel) == 1);

  // R3
  rd_after_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_valid));

  // R2
  reserved_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_byte[4] || cmd_byte[1] || cmd_byte[0])) |=> (!rd_valid && $stable(tap_sel)));

  // R10
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop));

  // R11
  busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ($stable(tap_sel) && !rd_valid));

endmodule

bind pot_exec pot_exec_chk #(.TAPS(TAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .stop(stop), .rd_valid(rd_valid), .busy(busy), .tap_sel(tap_sel)
);

// File: tb/sim_pot_exec.sv
module sim_pot_exec;
  localparam int NB = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic [7:0]  cmd_byte = 0;
  logic        rw_bit = 0;
  logic [7:0]  wr_hi = 0;
  logic [7:0]  wr_lo = 0;
  logic        stop = 0;
  logic        rd_valid;
  logic [7:0]  rd_hi, rd_lo;
  logic [1023:0] tap_sel;
  logic        busy;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pot_exec #(.W(10), .BUSY_CYCLES(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .rw_bit(rw_bit), .wr_hi(wr_hi), .wr_lo(wr_lo), .stop(stop),
    .rd_valid(rd_valid), .rd_hi(rd_hi), .rd_lo(rd_lo), .tap_sel(tap_sel),
    .busy(busy)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [1:0] ptr, input logic rw,
                        input logic [9:0] v, input logic [7:0] rsv);
    @(negedge clk);
    cmd_valid = 1;
    cmd_byte  = {op, 1'b0, ptr, 2'b00} | rsv;
    rw_bit    = rw;
    wr_hi     = {6'b101101, v[9:8]};
    wr_lo     = v[7:0];
    @(negedge clk);
    cmd_valid = 0;
    cmd_byte  = 0;
  endtask

  task automatic chk_tap(input string tag, input logic [9:0] v);
    check(tag, {31'b0, tap_sel[v]}, 32'd1);
    check(tag, $countones(tap_sel), 32'd1);
  endtask

  task automatic chk_read(input string tag, input logic [2:0] op, input logic [1:0] ptr,
                          input logic [9:0] exp);
    do_cmd(op, ptr, 1'b1, 10'h0, 8'h0);
    check(tag, {31'b0, rd_valid}, 32'd1);
    check(tag, {16'b0, rd_hi, rd_lo}, {22'b0, exp});
  endtask

  task automatic pulse_stop_wait(input string tag, input int exp_len);
    int n;
    @(negedge clk);
    stop = 1;
    @(negedge clk);
    stop = 0;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
    check(tag, n, exp_len);
  endtask

  task automatic t_reset;
    check("R1 busy", {31'b0, busy}, 0);
    check("R1 rd_valid", {31'b0, rd_valid}, 0);
    chk_tap("R1 tap", 10'h000);
    chk_read("R1 wiper", 3'b100, 2'd0, 10'h000);
    for (int i = 0; i < 4; i++) chk_read("R1 dr", 3'b101, 2'(i), 10'h000);
  endtask

  task automatic t_wiper;
    do_cmd(3'b101, 2'd0, 1'b0, 10'h3FF, 8'h0);
    chk_tap("R4 R9 high end", 10'h3FF);
    chk_read("R3 read 3FF", 3'b100, 2'd0, 10'h3FF);
    do_cmd(3'b101, 2'd0, 1'b0, 10'h000, 8'h0);
    chk_tap("R9 low end", 10'h000);
    do_cmd(3'b101, 2'd0, 1'b0, 10'h155, 8'h0);
    chk_tap("R4 mid", 10'h155);
    chk_read("R3 read 155", 3'b100, 2'd0, 10'h155);
    @(negedge clk);
    check("R3 rd_valid one cycle", {31'b0, rd_valid}, 0);
  endtask

  task automatic t_dr;
    logic [9:0] vals [4];
    vals = '{10'h012, 10'h3C5, 10'h2A0, 10'h1FF};
    for (int i = 0; i < 4; i++) do_cmd(3'b110, 2'(i), 1'b0, vals[i], 8'h0);
    pulse_stop_wait("R10 busy length", NB);
    for (int i = 0; i < 4; i++) chk_read("R5 R6 dr readback", 3'b101, 2'(i), vals[i]);
  endtask

  task automatic t_xfer;
    do_cmd(3'b110, 2'd2, 1'b1, 10'h0, 8'h0);
    chk_tap("R7 dr2 to wiper", 10'h2A0);
    chk_read("R7 wiper", 3'b100, 2'd0, 10'h2A0);
    do_cmd(3'b101, 2'd0, 1'b0, 10'h2A5, 8'h0);
    do_cmd(3'b111, 2'd1, 1'b0, 10'h0, 8'h0);
    pulse_stop_wait("R8 R10 busy after copy", NB);
    chk_read("R8 dr1", 3'b101, 2'd1, 10'h2A5);
    chk_read("R8 dr0 untouched", 3'b101, 2'd0, 10'h012);
  endtask

  task automatic t_illegal;
    do_cmd(3'b101, 2'd0, 1'b0, 10'h0AA, 8'h10);
    chk_tap("R2 bit4 set write", 10'h2A5);
    do_cmd(3'b100, 2'd0, 1'b1, 10'h0, 8'h01);
    check("R2 bit0 set read", {31'b0, rd_valid}, 0);
    do_cmd(3'b110, 2'd3, 1'b0, 10'h077, 8'h02);
    chk_read("R2 bit1 set dr write", 3'b101, 2'd3, 10'h1FF);
    do_cmd(3'b100, 2'd0, 1'b0, 10'h0AA, 8'h0);
    chk_tap("R12 100 write", 10'h2A5);
    do_cmd(3'b111, 2'd0, 1'b1, 10'h0, 8'h0);
    check("R12 111 read", {31'b0, rd_valid}, 0);
    do_cmd(3'b000, 2'd0, 1'b0, 10'h0AA, 8'h0);
    chk_read("R12 000 write", 3'b100, 2'd0, 10'h2A5);
    pulse_stop_wait("R10 no pending store", 0);
  endtask

  task automatic t_busy;
    do_cmd(3'b110, 2'd3, 1'b0, 10'h0C3, 8'h0);
    @(negedge clk);
    stop = 1;
    @(negedge clk);
    stop = 0;
    check("R10 busy raised", {31'b0, busy}, 1);
    do_cmd(3'b101, 2'd0, 1'b0, 10'h001, 8'h0);
    chk_tap("R11 write while busy", 10'h2A5);
    do_cmd(3'b100, 2'd0, 1'b1, 10'h0, 8'h0);
    check("R11 read while busy", {31'b0, rd_valid}, 0);
    do_cmd(3'b110, 2'd0, 1'b0, 10'h111, 8'h0);
    while (busy) @(negedge clk);
    chk_read("R11 dr0 kept", 3'b101, 2'd0, 10'h012);
    chk_read("R6 dr3 stored", 3'b101, 2'd3, 10'h0C3);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_wiper;
        t_dr;
        t_xfer;
        t_illegal;
        t_busy;
      end
      begin
        repeat (20000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule